// File: doc/BRIEF.md
# Virtual Interrupt Priority Arbiter

This block chooses which pending virtual interrupt a virtualized processor should see next, and decides whether that interrupt may be raised right now. It weighs a bank of list-register entries against one directly injected virtual LPI. The list-register entries are held elsewhere and presented here as flat vectors. The winner is checked against the virtual interface enable, the virtual priority mask, and the group-priority preemption rule relative to the current running priority. A signalled group 0 winner drives the FIQ line and a signalled group 1 winner drives the IRQ line.

All inputs, including the secure-state flag and the running priority, are captured into a snapshot register on every rising edge. The selection, the reported winner and both interrupt lines are computed combinationally from that snapshot. Any input change, including a change of security state on an exception-level switch, is therefore reflected one clock later. A winning vLPI is reported with the reserved index NUM_LR (16 by default), one above the highest list-register index.

Top module: `virt_irq_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, with no inputs applied, `hpValid`, `hpIndex`, `hpId`, `irqOut` and `fiqOut` are all zero.
- R2: A list-register entry is a candidate when its pending bit is set and its group's enable is set (`vEnG0` for group bit 0, `vEnG1` for group bit 1). Among candidates, the numerically lowest priority below 0xFF wins, and equal priorities go to the lowest index. `hpIndex` gives that index and `hpId` gives that entry's ID.
- R3: The vLPI wins only when `isSecure` is 0, its group's enable is set, and `vlpiPrio` is strictly less than the best candidate list-register priority (0xFF when there is none). It is then reported as `hpIndex` = NUM_LR (16) with `hpId` = `vlpiId`. A vLPI priority of 0xFF never wins.
- R4: When nothing wins, `hpValid` is 0, `hpIndex` and `hpId` are 0, and neither interrupt line is raised.
- R5: With `vIfEn` at 0, neither `irqOut` nor `fiqOut` is raised, although `hpValid` and `hpIndex` still report the winner.
- R6: A winner whose priority is greater than or equal to `vPmr` is not signalled.
- R7: When `runPrio` is 0xFF, an enabled and unmasked winner is always signalled.
- R8: Otherwise the winner is signalled only if (prio & M) < (runPrio & M). For a group 0 winner M = 0xFF << (vBp0+1), and for a group 1 winner M = 0xFF << vBp1. The subpriority bits below M are ignored.
- R9: A signalled group 0 winner raises `fiqOut` only, and a signalled group 1 winner raises `irqOut` only. The two lines are never high together.
- R10: The outputs follow the inputs present at the previous rising clock edge and no older ones. A change of `isSecure` or of any enable moves the outputs exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lrPending | input | NUM_LR | Pending bit of each list-register entry |
| lrGroup1 | input | NUM_LR | Group bit of each entry (1 = group 1) |
| lrPrio | input | NUM_LR*PRIO_W | Priority of each entry, entry i in bits [i*PRIO_W +: PRIO_W] |
| lrId | input | NUM_LR*ID_W | Interrupt ID of each entry, entry i in bits [i*ID_W +: ID_W] |
| vlpiPrio | input | PRIO_W | Priority of the pending vLPI, all ones when none |
| vlpiGroup1 | input | 1 | Group of the vLPI (1 = group 1) |
| vlpiId | input | ID_W | Interrupt ID of the vLPI |
| vIfEn | input | 1 | Virtual interface enable |
| vEnG0 | input | 1 | Virtual group 0 enable |
| vEnG1 | input | 1 | Virtual group 1 enable |
| vPmr | input | PRIO_W | Virtual priority mask |
| vBp0 | input | BP_W | Group 0 binary point |
| vBp1 | input | BP_W | Group 1 binary point |
| isSecure | input | 1 | Processor is in secure state |
| runPrio | input | PRIO_W | Current running priority, all ones when idle |
| hpValid | output | 1 | A winner exists |
| hpIndex | output | IDX_W | Winning entry index, NUM_LR for the vLPI |
| hpId | output | ID_W | Interrupt ID of the winner |
| irqOut | output | 1 | Virtual IRQ line |
| fiqOut | output | 1 | Virtual FIQ line |

## Verification
The cycle-delayed assertions assume every input is stable around the rising edge that loads the snapshot. A consequent checked one cycle later then relates to exactly the values that were captured. The bench respects this by changing inputs only on the falling edge and reading outputs on the following falling edge. The assertions also assume that no list-register entry and no vLPI with a priority of 0xFF is expected to win. The stimulus uses 0xFF only to stand for "no vLPI" or to exercise that exclusion.

// File: rtl/vpa_pkg.sv
package vpa_pkg;

  // Comparison results the datapath hands to the control.
  typedef struct packed {
    logic lrFound;
    logic lrGrp1;
    logic lrCanSig;
    logic vlpiBeats;
    logic vlpiGrp1;
    logic vlpiCanSig;
  } arbStatus_t;

  // Decisions the control hands back to the datapath and top.
  typedef struct packed {
    logic selVlpi;
    logic anyValid;
    logic raiseIrq;
    logic raiseFiq;
  } arbStrobe_t;

endpackage

// File: rtl/via_control.sv
module via_control
  import vpa_pkg::*;
(
  input  arbStatus_t status,
  output arbStrobe_t strobe
);

  logic winGrp1;
  logic winCanSig;

  always_comb begin
    winGrp1   = status.vlpiBeats ? status.vlpiGrp1 : status.lrGrp1;
    winCanSig = status.vlpiBeats ? status.vlpiCanSig
                                 : (status.lrFound && status.lrCanSig);

    strobe.selVlpi  = status.vlpiBeats;
    strobe.anyValid = status.vlpiBeats || status.lrFound;
    strobe.raiseIrq = winCanSig && winGrp1;
    strobe.raiseFiq = winCanSig && !winGrp1;
  end

endmodule

// File: rtl/via_datapath.sv
module via_datapath
  import vpa_pkg::*;
#(
  parameter int NUM_LR = 16,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 16,
  parameter int BP_W   = 3,
  localparam int IDX_W = $clog2(NUM_LR + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_LR-1:0]        lrPending,
  input  logic [NUM_LR-1:0]        lrGroup1,
  input  logic [NUM_LR*PRIO_W-1:0] lrPrio,
  input  logic [NUM_LR*ID_W-1:0]   lrId,
  input  logic [PRIO_W-1:0]        vlpiPrio,
  input  logic                     vlpiGroup1,
  input  logic [ID_W-1:0]          vlpiId,
  input  logic                     vIfEn,
  input  logic                     vEnG0,
  input  logic                     vEnG1,
  input  logic [PRIO_W-1:0]        vPmr,
  input  logic [BP_W-1:0]          vBp0,
  input  logic [BP_W-1:0]          vBp1,
  input  logic                     isSecure,
  input  logic [PRIO_W-1:0]        runPrio,
  input  arbStrobe_t               strobe,
  output arbStatus_t               status,
  output logic                     hpValid,
  output logic [IDX_W-1:0]         hpIndex,
  output logic [ID_W-1:0]          hpId
);

  localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

  // Input snapshot
  logic [NUM_LR-1:0]        lrPendR, lrGrp1R;
  logic [NUM_LR*PRIO_W-1:0] lrPrioR;
  logic [NUM_LR*ID_W-1:0]   lrIdR;
  logic [PRIO_W-1:0]        vlpiPrioR, vPmrR, runPrioR;
  logic                     vlpiGrp1R, vIfEnR, vEnG0R, vEnG1R, isSecureR;
  logic [ID_W-1:0]          vlpiIdR;
  logic [BP_W-1:0]          vBp0R, vBp1R;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lrPendR   <= '0;
      lrGrp1R   <= '0;
      lrPrioR   <= '1;
      lrIdR     <= '0;
      vlpiPrioR <= PRIO_IDLE;
      vlpiGrp1R <= 1'b0;
      vlpiIdR   <= '0;
      vIfEnR    <= 1'b0;
      vEnG0R    <= 1'b0;
      vEnG1R    <= 1'b0;
      vPmrR     <= '0;
      vBp0R     <= '0;
      vBp1R     <= '0;
      isSecureR <= 1'b1;
      runPrioR  <= PRIO_IDLE;
    end else begin
      lrPendR   <= lrPending;
      lrGrp1R   <= lrGroup1;
      lrPrioR   <= lrPrio;
      lrIdR     <= lrId;
      vlpiPrioR <= vlpiPrio;
      vlpiGrp1R <= vlpiGroup1;
      vlpiIdR   <= vlpiId;
      vIfEnR    <= vIfEn;
      vEnG0R    <= vEnG0;
      vEnG1R    <= vEnG1;
      vPmrR     <= vPmr;
      vBp0R     <= vBp0;
      vBp1R     <= vBp1;
      isSecureR <= isSecure;
      runPrioR  <= runPrio;
    end
  end

  // Per-entry eligibility: pending and its group enabled
  logic [NUM_LR-1:0] lrElig;
  for (genvar g = 0; g < NUM_LR; g++) begin : g_elig
    assign lrElig[g] = lrPendR[g] && (lrGrp1R[g] ? vEnG1R : vEnG0R);
  end

  // Scan: strict less-than keeps the lowest index on ties and drops 0xFF
  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  bestIdx;
  logic [ID_W-1:0]   bestId;
  logic              bestGrp1;
  logic              bestFound;

  always_comb begin
    bestPrio  = PRIO_IDLE;
    bestIdx   = '0;
    bestId    = '0;
    bestGrp1  = 1'b0;
    bestFound = 1'b0;
    for (int i = 0; i < NUM_LR; i++) begin
      if (lrElig[i] && (lrPrioR[i*PRIO_W +: PRIO_W] < bestPrio)) begin
        bestPrio  = lrPrioR[i*PRIO_W +: PRIO_W];
        bestIdx   = IDX_W'(i);
        bestId    = lrIdR[i*ID_W +: ID_W];
        bestGrp1  = lrGrp1R[i];
        bestFound = 1'b1;
      end
    end
  end

  // Group priority masks
  logic [PRIO_W-1:0] mask0, mask1, lrMask, vlpiMask;
  assign mask0    = PRIO_IDLE << (32'(vBp0R) + 1);
  assign mask1    = PRIO_IDLE << 32'(vBp1R);
  assign lrMask   = bestGrp1 ? mask1 : mask0;
  assign vlpiMask = vlpiGrp1R ? mask1 : mask0;

  function automatic logic preemptOk(input logic en,
                                     input logic [PRIO_W-1:0] prio,
                                     input logic [PRIO_W-1:0] pmr,
                                     input logic [PRIO_W-1:0] run,
                                     input logic [PRIO_W-1:0] mask);
    return en && (prio < pmr) &&
           ((run == PRIO_IDLE) || ((prio & mask) < (run & mask)));
  endfunction

  logic vlpiEn;
  assign vlpiEn = vlpiGrp1R ? vEnG1R : vEnG0R;

  always_comb begin
    status.lrFound    = bestFound;
    status.lrGrp1     = bestGrp1;
    status.lrCanSig   = preemptOk(vIfEnR, bestPrio, vPmrR, runPrioR, lrMask);
    status.vlpiBeats  = !isSecureR && vlpiEn && (vlpiPrioR < bestPrio);
    status.vlpiGrp1   = vlpiGrp1R;
    status.vlpiCanSig = preemptOk(vIfEnR, vlpiPrioR, vPmrR, runPrioR, vlpiMask);
  end

  // Winner report
  always_comb begin
    hpValid = strobe.anyValid;
    hpIndex = '0;
    hpId    = '0;
    if (strobe.selVlpi) begin
      hpIndex = IDX_W'(NUM_LR);
      hpId    = vlpiIdR;
    end else if (strobe.anyValid) begin
      hpIndex = bestIdx;
      hpId    = bestId;
    end
  end

endmodule

// File: rtl/virt_irq_arbiter.sv
module virt_irq_arbiter
  import vpa_pkg::*;
#(
  parameter int NUM_LR = 16,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 16,
  parameter int BP_W   = 3,
  localparam int IDX_W = $clog2(NUM_LR + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_LR-1:0]        lrPending,
  input  logic [NUM_LR-1:0]        lrGroup1,
  input  logic [NUM_LR*PRIO_W-1:0] lrPrio,
  input  logic [NUM_LR*ID_W-1:0]   lrId,
  input  logic [PRIO_W-1:0]        vlpiPrio,
  input  logic                     vlpiGroup1,
  input  logic [ID_W-1:0]          vlpiId,
  input  logic                     vIfEn,
  input  logic                     vEnG0,
  input  logic                     vEnG1,
  input  logic [PRIO_W-1:0]        vPmr,
  input  logic [BP_W-1:0]          vBp0,
  input  logic [BP_W-1:0]          vBp1,
  input  logic                     isSecure,
  input  logic [PRIO_W-1:0]        runPrio,
  output logic                     hpValid,
  output logic [IDX_W-1:0]         hpIndex,
  output logic [ID_W-1:0]          hpId,
  output logic                     irqOut,
  output logic                     fiqOut
);

  arbStatus_t status;
  arbStrobe_t strobe;

  via_datapath #(
    .NUM_LR(NUM_LR), .PRIO_W(PRIO_W), .ID_W(ID_W), .BP_W(BP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .lrPending(lrPending), .lrGroup1(lrGroup1), .lrPrio(lrPrio), .lrId(lrId),
    .vlpiPrio(vlpiPrio), .vlpiGroup1(vlpiGroup1), .vlpiId(vlpiId),
    .vIfEn(vIfEn), .vEnG0(vEnG0), .vEnG1(vEnG1), .vPmr(vPmr),
    .vBp0(vBp0), .vBp1(vBp1), .isSecure(isSecure), .runPrio(runPrio),
    .strobe(strobe), .status(status),
    .hpValid(hpValid), .hpIndex(hpIndex), .hpId(hpId)
  );

  via_control u_ctl (
    .status(status),
    .strobe(strobe)
  );

  assign irqOut = strobe.raiseIrq;
  assign fiqOut = strobe.raiseFiq;

endmodule

// File: rtl/via_checks.sv
module via_checks #(
  parameter int NUM_LR = 16,
  parameter int PRIO_W = 8,
  localparam int IDX_W = $clog2(NUM_LR + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              vIfEn,
  input logic              isSecure,
  input logic [PRIO_W-1:0] vPmr,
  input logic              irqOut,
  input logic              fiqOut,
  input logic              hpValid,
  input logic [IDX_W-1:0]  hpIndex
);

  // R9: never both lines at once
  a_r9_single_line: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && fiqOut));

  // R4: a raised line always has a winner behind it
  a_r4_line_needs_winner: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || fiqOut) |-> hpValid);

  // R4: no winner reports index zero
  a_r4_idle_index: assert property (@(posedge clk) disable iff (!rstN)
    !hpValid |-> (hpIndex == '0));

  // R2: index never beyond the reserved vLPI value
  a_r2_index_range: assert property (@(posedge clk) disable iff (!rstN)
    hpIndex <= IDX_W'(NUM_LR));

  // R5: interface disabled silences both lines one cycle later
  a_r5_if_off: assert property (@(posedge clk) disable iff (!rstN)
    !vIfEn |=> (!irqOut && !fiqOut));

  // R6: a zero mask masks every priority
  a_r6_mask_zero: assert property (@(posedge clk) disable iff (!rstN)
    (vPmr == '0) |=> (!irqOut && !fiqOut));

  // R3: secure state never reports the vLPI
  a_r3_secure_no_vlpi: assert property (@(posedge clk) disable iff (!rstN)
    isSecure |=> (hpIndex != IDX_W'(NUM_LR)));

endmodule

bind virt_irq_arbiter via_checks #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W)) u_checks (
  .clk(clk), .rstN(rstN), .vIfEn(vIfEn), .isSecure(isSecure), .vPmr(vPmr),
  .irqOut(irqOut), .fiqOut(fiqOut), .hpValid(hpValid), .hpIndex(hpIndex)
);

// File: tb/sim_virt_irq_arbiter.sv
`timescale 1ns/1ps
module sim_virt_irq_arbiter;

  localparam int NUM_LR = 16;
  localparam int PRIO_W = 8;
  localparam int ID_W   = 16;
  localparam int BP_W   = 3;
  localparam int IDX_W  = $clog2(NUM_LR + 1);

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic [NUM_LR-1:0]        lrPending;
  logic [NUM_LR-1:0]        lrGroup1;
  logic [NUM_LR*PRIO_W-1:0] lrPrio;
  logic [NUM_LR*ID_W-1:0]   lrId;
  logic [PRIO_W-1:0]        vlpiPrio;
  logic                     vlpiGroup1;
  logic [ID_W-1:0]          vlpiId;
  logic                     vIfEn, vEnG0, vEnG1, isSecure;
  logic [PRIO_W-1:0]        vPmr, runPrio;
  logic [BP_W-1:0]          vBp0, vBp1;
  logic                     hpValid, irqOut, fiqOut;
  logic [IDX_W-1:0]         hpIndex;
  logic [ID_W-1:0]          hpId;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  virt_irq_arbiter #(.NUM_LR(NUM_LR), .PRIO_W(PRIO_W), .ID_W(ID_W), .BP_W(BP_W)) u0 (
    .clk(clk), .rstN(rstN),
    .lrPending(lrPending), .lrGroup1(lrGroup1), .lrPrio(lrPrio), .lrId(lrId),
    .vlpiPrio(vlpiPrio), .vlpiGroup1(vlpiGroup1), .vlpiId(vlpiId),
    .vIfEn(vIfEn), .vEnG0(vEnG0), .vEnG1(vEnG1), .vPmr(vPmr),
    .vBp0(vBp0), .vBp1(vBp1), .isSecure(isSecure), .runPrio(runPrio),
    .hpValid(hpValid), .hpIndex(hpIndex), .hpId(hpId),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLr(input int idx, input logic [7:0] prio, input logic g1, input logic pend);
    lrPrio[idx*PRIO_W +: PRIO_W] = prio;
    lrGroup1[idx] = g1;
    lrPending[idx] = pend;
  endtask

  task automatic clearAll();
    lrPending  = '0;
    lrGroup1   = '0;
    lrPrio     = '1;
    for (int i = 0; i < NUM_LR; i++) lrId[i*ID_W +: ID_W] = ID_W'(16'h0100 + i);
    vlpiPrio   = 8'hFF;
    vlpiGroup1 = 1'b1;
    vlpiId     = 16'h2345;
    vIfEn      = 1'b1;
    vEnG0      = 1'b1;
    vEnG1      = 1'b1;
    vPmr       = 8'hFF;
    vBp0       = '0;
    vBp1       = '0;
    isSecure   = 1'b0;
    runPrio    = 8'hFF;
  endtask

  task automatic tReset();
    chk("R1 valid in reset", hpValid, 0);
    chk("R1 irq in reset", irqOut, 0);
    chk("R1 fiq in reset", fiqOut, 0);
    chk("R1 index in reset", hpIndex, 0);
    chk("R1 id in reset", hpId, 0);
  endtask

  task automatic tLrPick();
    clearAll();
    setLr(5, 8'h40, 1, 1);
    setLr(9, 8'h40, 1, 1);
    setLr(3, 8'h80, 0, 1);
    step();
    chk("R2 tie lowest index", hpIndex, 5);
    chk("R2 winner id", hpId, 16'h0105);
    chk("R9 group1 irq", irqOut, 1);
    chk("R9 group1 no fiq", fiqOut, 0);
    vEnG1 = 1'b0;
    step();
    chk("R2 group1 disabled index", hpIndex, 3);
    chk("R2 group1 disabled id", hpId, 16'h0103);
    chk("R9 group0 fiq", fiqOut, 1);
    chk("R9 group0 no irq", irqOut, 0);
    clearAll();
    setLr(2, 8'hFF, 1, 1);
    step();
    chk("R2 prio FF entry ignored", hpValid, 0);
  endtask

  task automatic tVlpi();
    clearAll();
    setLr(5, 8'h40, 1, 1);
    vlpiPrio = 8'h20;
    step();
    chk("R3 vlpi index", hpIndex, NUM_LR);
    chk("R3 vlpi id", hpId, 16'h2345);
    chk("R3 vlpi irq", irqOut, 1);
    isSecure = 1'b1;
    step();
    chk("R3 secure hides vlpi", hpIndex, 5);
    chk("R10 secure change id", hpId, 16'h0105);
    isSecure = 1'b0;
    vlpiPrio = 8'h40;
    step();
    chk("R3 equal prio loses", hpIndex, 5);
    vlpiPrio = 8'h20;
    vlpiGroup1 = 1'b0;
    vEnG0 = 1'b0;
    step();
    chk("R3 group0 disabled vlpi", hpIndex, 5);
    vEnG0 = 1'b1;
    step();
    chk("R3 group0 enabled vlpi", hpIndex, NUM_LR);
    chk("R9 vlpi group0 fiq", fiqOut, 1);
    chk("R9 vlpi group0 no irq", irqOut, 0);
    lrPending = '0;
    vlpiPrio = 8'hFF;
    step();
    chk("R4 none valid", hpValid, 0);
    chk("R4 none index", hpIndex, 0);
    chk("R4 none id", hpId, 0);
    chk("R4 none irq", irqOut, 0);
    chk("R4 none fiq", fiqOut, 0);
  endtask

  task automatic tMask();
    clearAll();
    setLr(1, 8'h40, 1, 1);
    vIfEn = 1'b0;
    step();
    chk("R5 winner still valid", hpValid, 1);
    chk("R5 winner still index", hpIndex, 1);
    chk("R5 no irq", irqOut, 0);
    vIfEn = 1'b1;
    vPmr = 8'h40;
    step();
    chk("R6 equal mask blocks", irqOut, 0);
    vPmr = 8'h41;
    step();
    chk("R6 mask above passes", irqOut, 1);
    vlpiPrio = 8'h30;
    vPmr = 8'h30;
    step();
    chk("R6 vlpi selected", hpIndex, NUM_LR);
    chk("R6 vlpi masked", irqOut, 0);
    vPmr = 8'h31;
    step();
    chk("R6 vlpi unmasked", irqOut, 1);
  endtask

  task automatic tPreempt();
    clearAll();
    vlpiPrio = 8'h30;
    vBp1 = 3'd3;
    runPrio = 8'h34;
    step();
    chk("R8 g1 subprio ignored", irqOut, 0);
    runPrio = 8'h38;
    step();
    chk("R8 g1 group prio higher", irqOut, 1);
    runPrio = 8'hFF;
    vBp1 = 3'd7;
    step();
    chk("R7 idle running prio", irqOut, 1);
    vlpiGroup1 = 1'b0;
    vBp0 = 3'd3;
    runPrio = 8'h3F;
    step();
    chk("R8 g0 subprio ignored", fiqOut, 0);
    runPrio = 8'h40;
    step();
    chk("R8 g0 preempts", fiqOut, 1);
    clearAll();
    setLr(0, 8'h50, 0, 1);
    vBp0 = 3'd2;
    runPrio = 8'h57;
    step();
    chk("R8 lr same group prio", fiqOut, 0);
    runPrio = 8'h48;
    step();
    chk("R8 lr running higher", fiqOut, 0);
    runPrio = 8'h58;
    step();
    chk("R8 lr preempts", fiqOut, 1);
  endtask

  task automatic tLatency();
    clearAll();
    setLr(4, 8'h40, 1, 1);
    step();
    chk("R10 settled irq", irqOut, 1);
    vIfEn = 1'b0;
    #1;
    chk("R10 old value held", irqOut, 1);
    step();
    chk("R10 new value after edge", irqOut, 0);
    clearAll();
    vlpiPrio = 8'h10;
    step();
    isSecure = 1'b1;
    #1;
    chk("R10 vlpi held before edge", hpIndex, NUM_LR);
    step();
    chk("R10 secure after edge", hpValid, 0);
    chk("R10 secure irq drop", irqOut, 0);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog actual hung expected done");
    finishRun();
  end

  initial begin
    clearAll();
    lrPending = '0;
    vlpiPrio = 8'hFF;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    lrPending = '0;
    vlpiPrio = 8'hFF;
    step();
    chk("R1 first cycle valid", hpValid, 0);
    chk("R1 first cycle irq", irqOut, 0);
    tLrPick();
    tVlpi();
    tMask();
    tPreempt();
    tLatency();
    finishRun();
  end

endmodule